// File: doc/BRIEF.md
# Power-On Initialization and Configuration-Mode Sequencer

This block steps a programmable device from power-up to the point where it may load its configuration. After the core reset lets go, it counts pulses of a slow internal timer tick. The delay is longer when the mode pins select a mode in which the device drives the configuration clock. The block then erases configuration memory one word per clock. It releases the open-drain initialization indication and waits for the external active-low reset to be high. It takes a final sample of the three mode pins and enters the configuring state with the decoded mode on its outputs.

While configuring, two events send the sequencer back to the memory-clear state, after which the reset pin and the mode pins are sampled again. The first is an external reset held low for three consecutive timer ticks, which aborts the load. The second is a falling edge on the done/program pin, which requests a reprogram. A reserved mode code puts the block into a locked error state that holds the initialization indication low. The block has no data streams: every pin is a plain level or pulse control signal, and the memory-clear port has no back-pressure because memory accepts one word per clock.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `rst_n` is low the outputs are `init_low`=1, `clr_req`=0, `cfg_active`=0, `cfg_mode`=0, `is_master`=0 and `addr_down`=0.
- R2: For a non-master mode code, the memory clear starts on the clock edge of the 2^TMR_W-th `tick` pulse after reset, and not before.
- R3: For a master mode code, the power-on delay is 4*2^TMR_W tick pulses.
- R4: The clear holds `clr_req` high for exactly CLR_WORDS cycles with `clr_addr` stepping 0,1,...,CLR_WORDS-1, and `init_low` stays 1 throughout.
- R5: After the clear, `init_low` drops to 0. The block does not enter configuration while `ext_rst_n` is low.
- R6: Two clocks after `ext_rst_n` is seen high in the waiting state, `cfg_active` is 1 with the mode sampled from `mode_sel` in that second cycle. `mode_sel[2]`=M0, `mode_sel[1]`=M1, `mode_sel[0]`=M2. The decode for M0M1M2 is: 000 gives `cfg_mode`=1 (master serial); 001 gives 2 (master byte, address up); 011 gives 3 (master byte, address down); 101 gives 4 (peripheral byte); 111 gives 5 (slave serial). `is_master` is 1 for codes 1 to 3 and `addr_down` is 1 only for code 3.
- R7: A reserved code (010, 100, 110) gives `cfg_mode`=6, `init_low`=1 and `cfg_active`=0. The block stays there regardless of ticks, `ext_rst_n` or `prog_in`, until `rst_n` is asserted.
- R8: In configuration, `ext_rst_n` low across three consecutive tick pulses starts the clear on the third pulse's edge. Two pulses do not, and neither does a count broken by `ext_rst_n` going high.
- R9: In configuration, a high-to-low change of `prog_in` starts the clear one clock later. Outside configuration, such a change has no effect.
- R10: After an abort or a reprogram, the block goes through the clear and the reset wait again, and resamples `mode_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | One-cycle pulse from the slow internal timer |
| ext_rst_n | input | 1 | External reset pin, active low |
| mode_sel | input | 3 | Mode pins: [2]=M0, [1]=M1, [0]=M2 |
| prog_in | input | 1 | Done/program pin level |
| init_low | output | 1 | Pull-down enable for the open-drain initialization pin |
| clr_req | output | 1 | Memory-clear write request, one word per cycle |
| clr_addr | output | CLR_AW | Word address for the clear |
| cfg_active | output | 1 | Configuring state |
| cfg_mode | output | 3 | Decoded mode, 0 = none yet |
| is_master | output | 1 | Device drives the configuration clock |
| addr_down | output | 1 | Byte-wide master address counts down |

## Verification
The bench runs the power-on path for all eight mode codes. One tick short of the expected delay it checks that no clear has started, and on the expected tick it checks that the clear has begun, which separates the normal delay from the four-fold master delay. The clear addresses and the decoded outputs are checked for every code, so the reserved codes are distinguished from the five legal ones. Separate sequences hold the external reset low through the wait and change the mode pins during it. They send two-tick, interrupted and three-tick reset pulses to tell a real abort from a glitch, and they drive done/program edges both inside and outside configuration.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_CONFIG = 3'd4,
    ST_ERR    = 3'd5
  } seq_st_e;

  typedef enum logic [2:0] {
    MD_NONE   = 3'd0,
    MD_MSER   = 3'd1,
    MD_MUP    = 3'd2,
    MD_MDOWN  = 3'd3,
    MD_PERIPH = 3'd4,
    MD_SLAVE  = 3'd5,
    MD_RSVD   = 3'd6
  } cfg_mode_e;

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import cfg_boot_pkg::*;
(
  input  logic [2:0] code,      // [2]=M0 [1]=M1 [0]=M2
  output cfg_mode_e  mode,
  output logic       master,
  output logic       down,
  output logic       reserved
);

  always_comb begin
    unique case (code)
      3'b000:  mode = MD_MSER;
      3'b001:  mode = MD_MUP;
      3'b011:  mode = MD_MDOWN;
      3'b101:  mode = MD_PERIPH;
      3'b111:  mode = MD_SLAVE;
      default: mode = MD_RSVD;
    endcase
  end

  assign master   = (mode == MD_MSER) || (mode == MD_MUP) || (mode == MD_MDOWN);
  assign down     = (mode == MD_MDOWN);
  assign reserved = (mode == MD_RSVD);

endmodule

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int TMR_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic master,
  output logic done
);

  localparam int CW = TMR_W + 2;
  localparam logic [CW-1:0] LAST_SHORT = CW'((1 << TMR_W) - 1);
  localparam logic [CW-1:0] LAST_LONG  = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = master ? LAST_LONG : LAST_SHORT;
  assign done = en && tick && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!en)      cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/cfg_clear_sweep.sv
module cfg_clear_sweep #(
  parameter int WORDS = 64,
  parameter int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [AW-1:0] addr,
  output logic          last
);

  localparam logic [AW-1:0] TOP = AW'(WORDS - 1);

  logic [AW-1:0] addr_q;

  assign addr = addr_q;
  assign last = en && (addr_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (!en)    addr_q <= '0;
    else if (!last)  addr_q <= addr_q + AW'(1);
  end

endmodule

// File: rtl/cfg_abort_filter.sv
module cfg_abort_filter #(
  parameter int ABORT_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic ext_rst_n,
  input  logic prog_in,
  output logic abort,
  output logic reprog
);

  localparam int RW = $clog2(ABORT_TICKS + 1);
  localparam logic [RW-1:0] LAST = RW'(ABORT_TICKS - 1);

  logic [RW-1:0] low_cnt_q;
  logic          prog_q;

  assign abort  = en && tick && !ext_rst_n && (low_cnt_q == LAST);
  assign reprog = en && prog_q && !prog_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt_q <= '0;
    else if (!en || ext_rst_n) low_cnt_q <= '0;
    else if (tick && (low_cnt_q != LAST)) low_cnt_q <= low_cnt_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= 1'b1;
    else        prog_q <= prog_in;
  end

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter int TMR_W       = 14,
  parameter int CLR_WORDS   = 64,
  parameter int ABORT_TICKS = 3,
  localparam int CLR_AW     = (CLR_WORDS > 1) ? $clog2(CLR_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ext_rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              prog_in,
  output logic              init_low,
  output logic              clr_req,
  output logic [CLR_AW-1:0] clr_addr,
  output logic              cfg_active,
  output logic [2:0]        cfg_mode,
  output logic              is_master,
  output logic              addr_down
);

  seq_st_e   st_q, st_d;
  cfg_mode_e dec_mode, mode_q;
  logic      dec_master, dec_down, dec_rsvd;
  logic      master_q, down_q;
  logic      por_done, clr_last, abort, reprog;

  cfg_mode_decode u_dec (
    .code     (mode_sel),
    .mode     (dec_mode),
    .master   (dec_master),
    .down     (dec_down),
    .reserved (dec_rsvd)
  );

  cfg_por_timer #(.TMR_W(TMR_W)) u_por (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (st_q == ST_POR),
    .tick   (tick),
    .master (dec_master),
    .done   (por_done)
  );

  cfg_clear_sweep #(.WORDS(CLR_WORDS), .AW(CLR_AW)) u_clr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (st_q == ST_CLEAR),
    .addr  (clr_addr),
    .last  (clr_last)
  );

  cfg_abort_filter #(.ABORT_TICKS(ABORT_TICKS)) u_abt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (st_q == ST_CONFIG),
    .tick      (tick),
    .ext_rst_n (ext_rst_n),
    .prog_in   (prog_in),
    .abort     (abort),
    .reprog    (reprog)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_POR:    if (por_done)        st_d = ST_CLEAR;
      ST_CLEAR:  if (clr_last)        st_d = ST_WAIT;
      ST_WAIT:   if (ext_rst_n)       st_d = ST_SAMPLE;
      ST_SAMPLE: st_d = dec_rsvd ? ST_ERR : ST_CONFIG;
      ST_CONFIG: if (abort || reprog) st_d = ST_CLEAR;
      default:   st_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_POR;
      mode_q   <= MD_NONE;
      master_q <= 1'b0;
      down_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SAMPLE) begin
        mode_q   <= dec_mode;
        master_q <= dec_master;
        down_q   <= dec_down;
      end
    end
  end

  assign init_low   = (st_q == ST_POR) || (st_q == ST_CLEAR) || (st_q == ST_ERR);
  assign clr_req    = (st_q == ST_CLEAR);
  assign cfg_active = (st_q == ST_CONFIG);
  assign cfg_mode   = mode_q;
  assign is_master  = master_q;
  assign addr_down  = down_q;

endmodule

// File: rtl/cfg_boot_seq_chk.sv
module cfg_boot_seq_chk #(
  parameter int CLR_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_low,
  input logic              clr_req,
  input logic [CLR_AW-1:0] clr_addr,
  input logic              cfg_active,
  input logic [2:0]        cfg_mode,
  input logic              is_master,
  input logic              addr_down
);

  // R4
  clear_holds_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> init_low);

  // R4
  clear_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && $past(clr_req)) |-> (clr_addr == $past(clr_addr) + CLR_AW'(1)));

  // R5
  config_init_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_active |-> !init_low);

  // R6
  down_only_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_down |-> (is_master && cfg_mode == 3'd3));

  // R6
  master_mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (cfg_mode >= 3'd1 && cfg_mode <= 3'd3));

  // R10
  leave_config_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_active) |-> clr_req);

endmodule

bind cfg_boot_seq cfg_boot_seq_chk #(.CLR_AW(CLR_AW)) u_chk (.*);

// File: tb/test_cfg_boot_seq.sv
`timescale 1ns/1ps
module test_cfg_boot_seq;

  localparam int TMR_W = 3;
  localparam int WORDS = 4;
  localparam int AW    = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ext_rst_n = 1'b1, prog_in = 1'b1;
  logic [2:0] mode_sel = 3'b111;
  logic init_low, clr_req, cfg_active, is_master, addr_down;
  logic [AW-1:0] clr_addr;
  logic [2:0] cfg_mode;
  int vectors = 0, errors = 0;

  always #10 clk = ~clk;

  cfg_boot_seq #(.TMR_W(TMR_W), .CLR_WORDS(WORDS), .ABORT_TICKS(3)) i_cfg_boot_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_rst_n(ext_rst_n),
    .mode_sel(mode_sel), .prog_in(prog_in), .init_low(init_low),
    .clr_req(clr_req), .clr_addr(clr_addr), .cfg_active(cfg_active),
    .cfg_mode(cfg_mode), .is_master(is_master), .addr_down(addr_down)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pulse();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  function automatic int exp_mode(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b011: return 3;
      3'b101: return 4;
      3'b111: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic int exp_master(input logic [2:0] c);
    return (c[2] == 1'b0 && !(c[1] && !c[0])) ? 1 : 0;
  endfunction

  // from the clear entry negedge: walk the sweep and land in the waiting state
  task automatic walk_clear();
    check("R4 clear start addr", clr_addr, 0);
    for (int k = 1; k < WORDS; k++) begin
      step();
      check("R4 clear addr", clr_addr, k);
      check("R4 init low in clear", init_low, 1);
    end
    step();
    check("R4 clear length", clr_req, 0);
    check("R5 init released", init_low, 0);
  endtask

  task automatic power_up(input logic [2:0] code, input logic ext);
    int n;
    rst_n = 1'b0; mode_sel = code; ext_rst_n = ext; prog_in = 1'b1;
    step(); step();
    check("R1 init_low", init_low, 1);
    check("R1 clr_req", clr_req, 0);
    check("R1 cfg_active", cfg_active, 0);
    check("R1 cfg_mode", cfg_mode, 0);
    check("R1 is_master", is_master, 0);
    check("R1 addr_down", addr_down, 0);
    rst_n = 1'b1; step();
    n = (exp_master(code) == 1) ? 4 * (1 << TMR_W) : (1 << TMR_W);
    for (int i = 0; i < n - 1; i++) pulse();
    check(exp_master(code) == 1 ? "R3 no early clear" : "R2 no early clear", clr_req, 0);
    check("R2 init low in por", init_low, 1);
    pulse();
    check(exp_master(code) == 1 ? "R3 clear on last tick" : "R2 clear on last tick", clr_req, 1);
    walk_clear();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    // sweep of all mode codes through power-up
    for (int c = 0; c < 8; c++) begin
      power_up(3'(c), 1'b1);
      step(); step();
      check("R6 cfg_mode", cfg_mode, exp_mode(3'(c)));
      check("R6 is_master", is_master, exp_master(3'(c)));
      check("R6 addr_down", addr_down, (c == 3) ? 1 : 0);
      check(exp_mode(3'(c)) == 6 ? "R7 no config" : "R6 config", cfg_active,
            exp_mode(3'(c)) == 6 ? 0 : 1);
      check("R7 init on error", init_low, exp_mode(3'(c)) == 6 ? 1 : 0);
    end

    // reserved code lock: ticks, reset and program edge do nothing
    power_up(3'b100, 1'b1);
    step(); step();
    ext_rst_n = 1'b0;
    for (int i = 0; i < 4; i++) pulse();
    ext_rst_n = 1'b1; prog_in = 1'b0; step(); step(); prog_in = 1'b1;
    mode_sel = 3'b111; step(); step(); step();
    check("R7 locked init", init_low, 1);
    check("R7 locked active", cfg_active, 0);
    check("R7 locked clr", clr_req, 0);
    check("R7 locked mode", cfg_mode, 6);

    // external reset held through the wait, mode changes, program edge ignored
    power_up(3'b111, 1'b0);
    for (int i = 0; i < 5; i++) step();
    check("R5 wait holds off config", cfg_active, 0);
    check("R5 wait init free", init_low, 0);
    mode_sel = 3'b001; prog_in = 1'b0; step();
    check("R9 edge ignored outside config", clr_req, 0);
    prog_in = 1'b1; step();
    ext_rst_n = 1'b1; step(); step();
    check("R6 final sample mode", cfg_mode, 2);
    check("R6 final sample active", cfg_active, 1);

    // abort filtering
    ext_rst_n = 1'b0; pulse(); pulse();
    check("R8 two ticks no abort", cfg_active, 1);
    ext_rst_n = 1'b1; step(); ext_rst_n = 1'b0;
    pulse(); pulse();
    check("R8 interrupted no abort", cfg_active, 1);
    check("R8 interrupted no clear", clr_req, 0);
    pulse();
    check("R8 abort clears", clr_req, 1);
    check("R8 abort leaves config", cfg_active, 0);
    mode_sel = 3'b011; ext_rst_n = 1'b1;
    walk_clear();
    step(); step();
    check("R10 resample after abort", cfg_mode, 3);
    check("R10 addr_down after abort", addr_down, 1);

    // reprogram on falling program edge
    mode_sel = 3'b101;
    prog_in = 1'b0; step();
    check("R9 reprogram clears", clr_req, 1);
    prog_in = 1'b1;
    walk_clear();
    step(); step();
    check("R10 resample after reprogram", cfg_mode, 4);
    check("R10 master after reprogram", is_master, 0);
    check("R10 active after reprogram", cfg_active, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule